// File: doc/BRIEF.md
# Ethernet Transmit Error Sequencer

This block sits beside a MAC transmit datapath and turns its abnormal-event strobes into frame outcomes. It watches four faults: the transmit FIFO running dry, carrier sense dropping, the retransmission limit being hit, and a collision arriving too late in the frame. Carrier loss is a soft fault. The frame runs to its normal end and the fault is only reported. The other three are hard faults. They end the buffer at once, report it, and freeze the transmitter until the host issues a restart.

When the FIFO runs dry, the block does not simply stop. It sends a 32-bit tail made from the frame check sequence that the CRC generator would have appended, XORed with a non-zero mask, so the far end is certain to reject the frame. Each buffer ends with a one-cycle close strobe that carries a status word. A sticky transmit-error flag, cleared by writing one, collects every fault for the host.

Top module: `tx_fault_seq`

## Requirements
- R1: After reset, `halted`, `txe_flag`, `close_stb` and `tail_valid` are all 0.
- R2: An `underrun_evt` during an active frame makes `tail_valid` high for 4 cycles, starting the cycle after the strobe. `tail_data` carries the bytes of `fcs_in ^ TAIL_MASK`, least significant byte first. In the next cycle `close_stb` pulses with status bit 0 (underrun) set, and `halted` rises.
- R3: `txe_flag` goes high the cycle after any reported fault and stays high until a cycle with `evt_clr` high. If a fault and `evt_clr` arrive in the same cycle, the flag stays set.
- R4: `crs_lost_evt` in a frame with no collision so far sets `txe_flag` but neither halts nor closes the buffer. At `frame_end`, `close_stb` pulses with status bit 1 (carrier lost) set.
- R5: Carrier loss in a frame that has already seen a collision, or that sees one in the same cycle, is not reported. Status bit 1 stays 0 and the flag is untouched.
- R6: `retry_lim_evt` in an active frame pulses `close_stb` the next cycle with status bit 2 (retry limit) set and raises `halted`.
- R7: `coll_evt` with `tx_byte_cnt >= late_win` pulses `close_stb` the next cycle with status bit 3 (late collision) set and raises `halted`. A collision below the window neither closes nor halts.
- R8: Hard faults in the same cycle are ranked underrun first, then late collision, then retry limit. Only the winner's status bit is set.
- R9: While halted, `frame_start` and all fault strobes are ignored. `restart_cmd` alone returns the block to idle and drops `halted` the next cycle.
- R10: `restart_cmd` is ignored when the block is not halted. A frame in progress still closes normally at `frame_end`.
- R11: Fault strobes and `frame_end` outside an active frame produce no close, no flag and no halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Pulse: a new buffer begins transmission |
| frame_end | input | 1 | Pulse: the buffer finished normally |
| tx_byte_cnt | input | CNT_W | Bytes sent so far in the current frame |
| late_win | input | CNT_W | Late-collision window in bytes |
| underrun_evt | input | 1 | Transmit FIFO underrun strobe |
| crs_lost_evt | input | 1 | Carrier sense dropped strobe |
| coll_evt | input | 1 | Collision detected strobe |
| retry_lim_evt | input | 1 | Retransmission limit reached strobe |
| fcs_in | input | TAIL_BITS | Check sequence the CRC generator would append |
| restart_cmd | input | 1 | Host restart-transmit command pulse |
| evt_clr | input | 1 | Write-one clear of the error flag |
| tail_valid | output | 1 | A corrupt-tail byte is on `tail_data` |
| tail_data | output | 8 | Corrupt-tail byte |
| close_stb | output | 1 | One-cycle buffer close strobe |
| close_status | output | 4 | {late coll, retry limit, carrier lost, underrun} |
| txe_flag | output | 1 | Sticky transmit-error event flag |
| halted | output | 1 | Transmitter frozen awaiting restart |

## Verification
The bench drives several hard faults in one cycle and expects only the top-ranked status bit. An inverted or missing priority shows up as the wrong bit or as two bits in the close word. It raises carrier loss after an early collision and in frames without one, so a design that forgets the per-frame collision memory reports a spurious carrier fault. It checks the exact byte order and values of the corrupt tail, and the cycle in which the close comes after the last tail byte. It sends restart commands into an idle and an active transmitter, and fault strobes into a halted one. A design that resets on a stray restart, or acts on faults while frozen, loses the pending close or emits one that should not exist. Finally it lines a flag clear up with a new fault, so a clear-over-set ordering loses the event.

// File: rtl/txf_pkg.sv
// Shared types for the transmit error sequencer.
// Assumes: a single clock domain; status bit order is fixed by the close word.
package txf_pkg;

    // Hard-fault classification, in priority order of detection.
    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_UNDER = 2'd1,
        FLT_LATE  = 2'd2,
        FLT_RETRY = 2'd3
    } fault_e;

    // Sequencer state.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_TAIL   = 2'd2,
        ST_HALT   = 2'd3
    } seq_st_e;

    // Per-buffer close status; bit 0 is underrun, bit 3 is late collision.
    typedef struct packed {
        logic late_coll;
        logic retry_lim;
        logic crs_lost;
        logic underrun;
    } close_stat_t;

endpackage

// File: rtl/txf_classifier.sv
// Classifies the datapath strobes of one cycle into a hard fault and a
// reportable carrier loss.
// Assumes: strobes are meaningful only while a frame is active (the caller gates).
module txf_classifier
    import txf_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             underrun_i,
    input  logic             coll_i,
    input  logic             retry_i,
    input  logic             crs_lost_i,
    input  logic             coll_seen_i,
    input  logic [CNT_W-1:0] byte_cnt_i,
    input  logic [CNT_W-1:0] late_win_i,
    output fault_e           fault_o,
    output logic             csl_hit_o
);

    logic late_hit;

    // Late collision: a collision at or past the programmed byte window.
    always_comb late_hit = coll_i && (byte_cnt_i >= late_win_i);

    // Priority pick: underrun, then late collision, then retry limit.
    always_comb begin
        if (underrun_i)    fault_o = FLT_UNDER;
        else if (late_hit) fault_o = FLT_LATE;
        else if (retry_i)  fault_o = FLT_RETRY;
        else               fault_o = FLT_NONE;
    end

    // Carrier loss only counts when no collision has touched this frame.
    always_comb csl_hit_o = crs_lost_i && !coll_seen_i && !coll_i;

    // R8: an underrun always outranks the other faults.
    a_r8_under_first: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_i |-> fault_o == FLT_UNDER);

    // R8: a retry-limit result means no late collision was present.
    a_r8_retry_last: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o == FLT_RETRY |-> !(coll_i && byte_cnt_i >= late_win_i) && !underrun_i);

endmodule

// File: rtl/txf_tail_gen.sv
// Produces the corrupt frame tail: the expected check sequence XORed with a
// non-zero mask, sent one byte per cycle, least significant byte first.
// Assumes: TAIL_BITS is a multiple of 8; run_i stays high until done_o.
module txf_tail_gen #(
    parameter int          TAIL_BITS = 32,
    parameter logic [TAIL_BITS-1:0] TAIL_MASK = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [TAIL_BITS-1:0] fcs_i,
    input  logic                 run_i,
    output logic [7:0]           data_o,
    output logic                 done_o
);

    localparam int TAIL_BYTES = TAIL_BITS / 8;
    localparam int IDX_W      = (TAIL_BYTES > 1) ? $clog2(TAIL_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TAIL_BYTES - 1);

    logic [TAIL_BITS-1:0] shreg;
    logic [IDX_W-1:0]     idx;

    // Capture the poisoned sequence on load, then shift one byte per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            idx   <= '0;
        end else if (load_i) begin
            shreg <= fcs_i ^ TAIL_MASK;
            idx   <= '0;
        end else if (run_i) begin
            shreg <= shreg >> 8;
            idx   <= idx + 1'b1;
        end
    end

    // Current byte and last-byte marker.
    always_comb begin
        data_o = shreg[7:0];
        done_o = run_i && (idx == LAST_IDX);
    end

    // R2: a tail is never reloaded while one is being sent.
    a_r2_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> !load_i);

endmodule

// File: rtl/txf_evt_flag.sv
// Sticky transmit-error flag with write-one-to-clear; a new event wins over a
// clear in the same cycle.
// Assumes: set_i and clr_i are single-cycle qualified pulses.
module txf_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // Flag register: set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    // R3: a fault is never lost, even against a clear.
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R3: the flag holds until an explicit clear.
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o && !clr_i |=> flag_o);

endmodule

// File: rtl/tx_fault_seq.sv
// Transmit error sequencer: tracks one frame at a time and turns fault
// strobes into a buffer close with status, a corrupt tail on underrun, a
// sticky error flag and a halt that only a restart command releases.
// Assumes: frame_start/frame_end and fault strobes are one-cycle pulses from
// the transmit datapath; tx_byte_cnt is valid while a frame is active.
module tx_fault_seq
    import txf_pkg::*;
#(
    parameter int CNT_W     = 11,
    parameter int TAIL_BITS = 32,
    parameter logic [TAIL_BITS-1:0] TAIL_MASK = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 frame_end,
    input  logic [CNT_W-1:0]     tx_byte_cnt,
    input  logic [CNT_W-1:0]     late_win,
    input  logic                 underrun_evt,
    input  logic                 crs_lost_evt,
    input  logic                 coll_evt,
    input  logic                 retry_lim_evt,
    input  logic [TAIL_BITS-1:0] fcs_in,
    input  logic                 restart_cmd,
    input  logic                 evt_clr,
    output logic                 tail_valid,
    output logic [7:0]           tail_data,
    output logic                 close_stb,
    output logic [3:0]           close_status,
    output logic                 txe_flag,
    output logic                 halted
);

    seq_st_e     state;
    fault_e      fault;
    close_stat_t stat_q;
    logic        coll_seen;
    logic        csl_pend;
    logic        csl_hit;
    logic        active;
    logic        tail_load;
    logic        tail_done;
    logic        flag_set;

    always_comb active = (state == ST_ACTIVE);

    txf_classifier #(.CNT_W(CNT_W)) u_class (
        .clk         (clk),
        .rst_n       (rst_n),
        .underrun_i  (underrun_evt),
        .coll_i      (coll_evt),
        .retry_i     (retry_lim_evt),
        .crs_lost_i  (crs_lost_evt),
        .coll_seen_i (coll_seen),
        .byte_cnt_i  (tx_byte_cnt),
        .late_win_i  (late_win),
        .fault_o     (fault),
        .csl_hit_o   (csl_hit)
    );

    // Tail starts loading in the cycle the underrun is accepted.
    always_comb tail_load = active && (fault == FLT_UNDER);

    txf_tail_gen #(.TAIL_BITS(TAIL_BITS), .TAIL_MASK(TAIL_MASK)) u_tail (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tail_load),
        .fcs_i  (fcs_in),
        .run_i  (tail_valid),
        .data_o (tail_data),
        .done_o (tail_done)
    );

    // Any reportable fault in an active frame raises the flag.
    always_comb flag_set = active && ((fault != FLT_NONE) || csl_hit);

    txf_evt_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (evt_clr),
        .flag_o (txe_flag)
    );

    // Frame sequencer: accept frames, resolve faults, close buffers, halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            coll_seen <= 1'b0;
            csl_pend  <= 1'b0;
            close_stb <= 1'b0;
            stat_q    <= '0;
        end else begin
            close_stb <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (frame_start) begin
                        state     <= ST_ACTIVE;
                        coll_seen <= 1'b0;
                        csl_pend  <= 1'b0;
                    end
                end
                ST_ACTIVE: begin
                    unique case (fault)
                        FLT_UNDER: begin
                            state    <= ST_TAIL;
                            csl_pend <= csl_pend | csl_hit;
                        end
                        FLT_LATE: begin
                            state     <= ST_HALT;
                            close_stb <= 1'b1;
                            stat_q    <= '{late_coll: 1'b1, retry_lim: 1'b0,
                                           crs_lost: csl_pend, underrun: 1'b0};
                        end
                        FLT_RETRY: begin
                            state     <= ST_HALT;
                            close_stb <= 1'b1;
                            stat_q    <= '{late_coll: 1'b0, retry_lim: 1'b1,
                                           crs_lost: csl_pend | csl_hit, underrun: 1'b0};
                        end
                        default: begin
                            if (coll_evt) coll_seen <= 1'b1;
                            if (csl_hit)  csl_pend  <= 1'b1;
                            if (frame_end) begin
                                state     <= ST_IDLE;
                                close_stb <= 1'b1;
                                stat_q    <= '{late_coll: 1'b0, retry_lim: 1'b0,
                                               crs_lost: csl_pend | csl_hit, underrun: 1'b0};
                            end
                        end
                    endcase
                end
                ST_TAIL: begin
                    if (tail_done) begin
                        state     <= ST_HALT;
                        close_stb <= 1'b1;
                        stat_q    <= '{late_coll: 1'b0, retry_lim: 1'b0,
                                       crs_lost: csl_pend, underrun: 1'b1};
                    end
                end
                default: begin
                    if (restart_cmd) state <= ST_IDLE;
                end
            endcase
        end
    end

    // Output decode.
    always_comb begin
        tail_valid   = (state == ST_TAIL);
        halted       = (state == ST_HALT);
        close_status = stat_q;
    end

    // R9: a halt is only left through a restart command.
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted && !restart_cmd |=> halted);

    // R2: the end of a tail is followed by an underrun close.
    a_r2_tail_close: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tail_valid) |-> close_stb && close_status[0]);

    // R8: at most one hard-fault bit in any close word.
    a_r8_one_fatal: assert property (@(posedge clk) disable iff (!rst_n)
        close_stb |-> $onehot0({close_status[3], close_status[2], close_status[0]}));

    // R6: the close strobe lasts exactly one cycle.
    a_r6_close_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        close_stb |=> !close_stb);

    // R7: a hard-fault close is always accompanied by a halt.
    a_r7_fatal_halts: assert property (@(posedge clk) disable iff (!rst_n)
        close_stb && (close_status[3] || close_status[2]) |-> halted);

endmodule

// File: tb/tx_fault_seq_tb.sv
module tx_fault_seq_tb;

    localparam int CNT_W = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 0, frame_end = 0;
    logic [CNT_W-1:0] tx_byte_cnt = '0;
    logic [CNT_W-1:0] late_win = 11'd64;
    logic underrun_evt = 0, crs_lost_evt = 0, coll_evt = 0, retry_lim_evt = 0;
    logic [31:0] fcs_in = 32'h1234ABCD;
    logic restart_cmd = 0, evt_clr = 0;
    logic tail_valid, close_stb, txe_flag, halted;
    logic [7:0] tail_data;
    logic [3:0] close_status;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [3:0] exp_q[$];

    always #4 clk = ~clk;

    tx_fault_seq u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
        .tx_byte_cnt(tx_byte_cnt), .late_win(late_win), .underrun_evt(underrun_evt),
        .crs_lost_evt(crs_lost_evt), .coll_evt(coll_evt), .retry_lim_evt(retry_lim_evt),
        .fcs_in(fcs_in), .restart_cmd(restart_cmd), .evt_clr(evt_clr),
        .tail_valid(tail_valid), .tail_data(tail_data), .close_stb(close_stb),
        .close_status(close_status), .txe_flag(txe_flag), .halted(halted)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Driver side of the scoreboard: record an expected close word.
    task automatic expect_close(input logic [3:0] st);
        exp_q.push_back(st);
    endtask

    task automatic start_frame();
        frame_start = 1; tick(); frame_start = 0;
    endtask

    task automatic end_frame();
        frame_end = 1; tick(); frame_end = 0;
        tick();
    endtask

    task automatic restart();
        restart_cmd = 1; tick(); restart_cmd = 0;
    endtask

    task automatic clear_flag();
        evt_clr = 1; tick(); evt_clr = 0;
    endtask

    // Monitor side: every close must match the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && close_stb) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11 unexpected close actual=%0h expected=none", close_status);
            end else begin
                chk("R8 close status", {28'd0, close_status}, {28'd0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 halted", {31'd0, halted}, 0);
        chk("R1 flag", {31'd0, txe_flag}, 0);
        chk("R1 close", {31'd0, close_stb}, 0);
        chk("R1 tail", {31'd0, tail_valid}, 0);

        // Clean frame
        expect_close(4'b0000);
        start_frame(); end_frame();

        // R4 carrier loss without collision
        start_frame();
        crs_lost_evt = 1; tick(); crs_lost_evt = 0;
        chk("R4 flag", {31'd0, txe_flag}, 1);
        chk("R4 no halt", {31'd0, halted}, 0);
        chk("R4 no early close", {31'd0, close_stb}, 0);
        expect_close(4'b0010);
        end_frame();
        clear_flag();
        chk("R3 cleared", {31'd0, txe_flag}, 0);

        // R5 / R7 early collision then carrier loss
        start_frame();
        tx_byte_cnt = 11'd20;
        coll_evt = 1; tick(); coll_evt = 0;
        chk("R7 early coll no halt", {31'd0, halted}, 0);
        crs_lost_evt = 1; tick(); crs_lost_evt = 0;
        chk("R5 flag untouched", {31'd0, txe_flag}, 0);
        expect_close(4'b0000);
        end_frame();

        // R6 retry limit
        start_frame();
        expect_close(4'b0100);
        retry_lim_evt = 1; tick(); retry_lim_evt = 0;
        chk("R6 halted", {31'd0, halted}, 1);
        chk("R3 flag on retry", {31'd0, txe_flag}, 1);
        clear_flag();
        // R9 ignored while halted
        start_frame();
        underrun_evt = 1; crs_lost_evt = 1; tick(); underrun_evt = 0; crs_lost_evt = 0;
        frame_end = 1; tick(); frame_end = 0;
        chk("R9 no tail", {31'd0, tail_valid}, 0);
        chk("R9 flag quiet", {31'd0, txe_flag}, 0);
        chk("R9 still halted", {31'd0, halted}, 1);
        restart();
        chk("R9 released", {31'd0, halted}, 0);

        // R7 late collision at exact window
        start_frame();
        tx_byte_cnt = 11'd64;
        expect_close(4'b1000);
        coll_evt = 1; tick(); coll_evt = 0;
        chk("R7 halted", {31'd0, halted}, 1);
        restart();
        tx_byte_cnt = 11'd0;

        // R2 underrun with corrupt tail
        start_frame();
        expect_close(4'b0001);
        underrun_evt = 1; tick(); underrun_evt = 0;
        chk("R2 tail valid", {31'd0, tail_valid}, 1);
        chk("R2 byte0", {24'd0, tail_data}, 32'h32);
        tick(); chk("R2 byte1", {24'd0, tail_data}, 32'h54);
        tick(); chk("R2 byte2", {24'd0, tail_data}, 32'hCB);
        tick(); chk("R2 byte3", {24'd0, tail_data}, 32'hED);
        chk("R2 not halted in tail", {31'd0, halted}, 0);
        tick();
        chk("R2 close strobe", {31'd0, close_stb}, 1);
        chk("R2 halted", {31'd0, halted}, 1);
        chk("R2 tail done", {31'd0, tail_valid}, 0);
        restart();

        // R8 all three hard faults together
        start_frame();
        tx_byte_cnt = 11'd100;
        expect_close(4'b0001);
        underrun_evt = 1; coll_evt = 1; retry_lim_evt = 1; tick();
        underrun_evt = 0; coll_evt = 0; retry_lim_evt = 0;
        chk("R8 underrun wins", {31'd0, tail_valid}, 1);
        repeat (4) tick();
        restart();
        // R8 late collision over retry
        start_frame();
        expect_close(4'b1000);
        coll_evt = 1; retry_lim_evt = 1; tick(); coll_evt = 0; retry_lim_evt = 0;
        restart();
        tx_byte_cnt = 11'd0;
        clear_flag();

        // R10 restart while active ignored
        start_frame();
        restart();
        chk("R10 not halted", {31'd0, halted}, 0);
        expect_close(4'b0000);
        end_frame();

        // R11 strobes outside a frame
        tx_byte_cnt = 11'd100;
        retry_lim_evt = 1; coll_evt = 1; crs_lost_evt = 1; frame_end = 1; tick();
        retry_lim_evt = 0; coll_evt = 0; crs_lost_evt = 0; frame_end = 0;
        tick();
        chk("R11 no halt", {31'd0, halted}, 0);
        chk("R11 no flag", {31'd0, txe_flag}, 0);
        tx_byte_cnt = 11'd0;

        // R3 set beats clear
        start_frame();
        crs_lost_evt = 1; evt_clr = 1; tick(); crs_lost_evt = 0; evt_clr = 0;
        chk("R3 set over clear", {31'd0, txe_flag}, 1);
        expect_close(4'b0010);
        end_frame();

        tick();
        chk("R8 all closes seen", exp_q.size(), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule